// File: doc/BRIEF.md
# Interleaved SRAM Word-Line Decoder

This block decodes an access address and drives the word-lines of a 64-word by 16-bit static memory whose columns are interleaved four to one. Each of the 16 physical rows carries four logical words whose bits alternate across the row. The two low address bits pick one of four column groups. The four high address bits pick the row. A read pulse and a write pulse decide when the lines move.

Write enable is split in two. A row carries an active-low write line, and each column group carries its own active-high write line. A cell is written only where both are active, so the other three words in the same row are never disturbed. Every row also has a virtual-ground control. It is pulled low only on the accessed row, and only during a read.

A small controller has four states: HOLD, READ, WRITE and CLASH. It captures the address when an access begins and keeps it for the whole pulse. A behavioural storage array sits behind the drivers. It lets the bench watch the effect of the lines through write data and read data.

Top module: `ilv_wl_decoder`

The controller's transitions depend only on the pulses sampled at each rising clock edge:
- `go_read`: only `rd_pulse` is high, so the next state is READ.
- `go_write`: only `wr_pulse` is high, so the next state is WRITE.
- `go_clash`: both pulses are high, so the next state is CLASH.
- `go_hold`: neither pulse is high, so the next state is HOLD.

All four transitions can be taken from every state. The address register loads on entry to READ or WRITE from any other state.

## Requirements
- R1: During and after reset, every row is in hold: `row_rd_wl` = 0, `row_wr_wl_n` all ones and `row_vgnd` all ones. At the same time `grp_wr_wl` = 0, `col_sel` = 0 and `rd_data` = 0.
- R2: After a clock edge at which neither pulse was sampled high, all lines show the hold levels of R1.
- R3: During an access, `col_sel` is one-hot, with bit k set for address bits [1:0] = k. In hold it is zero.
- R4: During an access, exactly one bit of `row_rd_wl` is set, at index address[5:2].
- R5: During a read, the accessed row has `row_rd_wl` high and `row_vgnd` low. Every other row keeps `row_vgnd` high, all `row_wr_wl_n` bits stay high and `grp_wr_wl` is 0.
- R6: During a write, the accessed row has `row_rd_wl` high and `row_wr_wl_n` low. All `row_vgnd` bits stay high, and only `grp_wr_wl` bit address[1:0] is set.
- R7: After an edge with both pulses high, every line is in hold. No word is written and `rd_data` is unchanged.
- R8: The address is captured at the edge that enters READ or WRITE. Later address changes during the same pulse have no effect on the lines or the data. Moving straight from one mode to the other captures the address again.
- R9: Bit b of the word at address {row, k} lives at physical column 4*b + k of that row. A write changes only that word, and the other three words of the row keep their contents.
- R10: `rd_data` takes the accessed word at every edge where read lines are active, and keeps its value otherwise.
- R11: The lines change one clock edge after a pulse is sampled, never before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 6 | Word address: bits [5:2] pick the row, bits [1:0] pick the column group |
| rd_pulse | input | 1 | Read pulse |
| wr_pulse | input | 1 | Write pulse |
| wr_data | input | 16 | Data for the write driver |
| row_rd_wl | output | 16 | Per-row word-line, high in read and in write |
| row_wr_wl_n | output | 16 | Per-row write word-line, active low |
| row_vgnd | output | 16 | Per-row virtual ground, low only on the row being read |
| grp_wr_wl | output | 4 | Per-column-group write word-line |
| col_sel | output | 4 | One-hot bit-line multiplexer select |
| rd_data | output | 16 | Last word read |

## Verification
Some properties hold on every cycle and are checked by assertions:
- at most one active row and at most one active group;
- in a read, the virtual ground is low on the same row as the word-line;
- in a write, the group write line matches the column select;
- the line levels that follow a hold, a clash, or a pulse entry;
- stable lines while a pulse is held;
- `rd_data` does not change outside reads.

Other behaviour shows only through the bench's scenarios:
- data placement and the safety of half-selected words, seen through writes followed by reads of all four words in a row;
- which exact row and group an address reaches;
- that an address changed mid-pulse leaves its target untouched.

// File: rtl/ilv_wl_pkg.sv
package ilv_wl_pkg;

    // Controller states: idle rows, read access, write access, conflicting pulses
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_CLASH = 2'd3
    } wl_state_e;

endpackage

// File: rtl/ilv_wl_fsm.sv
module ilv_wl_fsm
    import ilv_wl_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_pulse,
    input  logic              wr_pulse,
    output wl_state_e         state,
    output logic [ADDR_W-1:0] lat_addr
);

    wl_state_e state_q;
    wl_state_e state_d;
    logic      load_addr;

    // Next-state choice: every state uses the same four named transitions
    always_comb begin
        state_d = ST_HOLD;
        unique case (state_q)
            ST_HOLD, ST_READ, ST_WRITE, ST_CLASH: begin
                if (rd_pulse && wr_pulse)   state_d = ST_CLASH;   // go_clash
                else if (rd_pulse)          state_d = ST_READ;    // go_read
                else if (wr_pulse)          state_d = ST_WRITE;   // go_write
                else                        state_d = ST_HOLD;    // go_hold
            end
            default:                        state_d = ST_HOLD;
        endcase
    end

    // Capture the address only on entry to an access state
    always_comb begin
        load_addr = 1'b0;
        unique case (state_d)
            ST_READ:  load_addr = (state_q != ST_READ);
            ST_WRITE: load_addr = (state_q != ST_WRITE);
            default:  load_addr = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr <= '0;
        end else if (load_addr) begin
            lat_addr <= addr;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/ilv_row_drv.sv
module ilv_row_drv
    import ilv_wl_pkg::*;
#(
    parameter int ROW_BITS = 4,
    parameter int NROW     = 1 << ROW_BITS
) (
    input  wl_state_e           state,
    input  logic [ROW_BITS-1:0] row_addr,
    output logic [NROW-1:0]     row_rd_wl,
    output logic [NROW-1:0]     row_wr_wl_n,
    output logic [NROW-1:0]     row_vgnd
);

    for (genvar r = 0; r < NROW; r++) begin : g_row
        logic hit;
        assign hit = (row_addr == ROW_BITS'(r));

        always_comb begin
            // hold levels unless this row is the accessed one
            row_rd_wl[r]   = 1'b0;
            row_wr_wl_n[r] = 1'b1;
            row_vgnd[r]    = 1'b1;
            unique case (state)
                ST_READ: begin
                    row_rd_wl[r] = hit;
                    row_vgnd[r]  = !hit;
                end
                ST_WRITE: begin
                    row_rd_wl[r]   = hit;
                    row_wr_wl_n[r] = !hit;
                end
                ST_HOLD, ST_CLASH: begin
                    row_rd_wl[r]   = 1'b0;
                end
                default: begin
                    row_rd_wl[r]   = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/ilv_col_drv.sv
module ilv_col_drv
    import ilv_wl_pkg::*;
#(
    parameter int COL_BITS = 2,
    parameter int NGRP     = 1 << COL_BITS
) (
    input  wl_state_e           state,
    input  logic [COL_BITS-1:0] col_addr,
    output logic [NGRP-1:0]     col_sel,
    output logic [NGRP-1:0]     grp_wr_wl
);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic hit;
        assign hit = (col_addr == COL_BITS'(g));

        always_comb begin
            col_sel[g]   = 1'b0;
            grp_wr_wl[g] = 1'b0;
            unique case (state)
                ST_READ: begin
                    col_sel[g] = hit;
                end
                ST_WRITE: begin
                    col_sel[g]   = hit;
                    grp_wr_wl[g] = hit;
                end
                ST_HOLD, ST_CLASH: begin
                    col_sel[g] = 1'b0;
                end
                default: begin
                    col_sel[g] = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/ilv_cell_array.sv
module ilv_cell_array #(
    parameter int NROW   = 16,
    parameter int NGRP   = 4,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NROW-1:0]   row_rd_wl,
    input  logic [NROW-1:0]   row_wr_wl_n,
    input  logic [NROW-1:0]   row_vgnd,
    input  logic [NGRP-1:0]   grp_wr_wl,
    input  logic [NGRP-1:0]   col_sel,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data
);

    localparam int NPHYS = WORD_W * NGRP;
    localparam int RB    = (NROW > 1) ? $clog2(NROW) : 1;
    localparam int CB    = (NGRP > 1) ? $clog2(NGRP) : 1;

    logic [NPHYS-1:0] cells [NROW];
    logic [RB-1:0]    rsel;
    logic [CB-1:0]    csel;
    logic             rhit;

    // A cell changes only where its row write line and its group write line meet
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NROW; r++) begin
                cells[r] <= '0;
            end
        end else begin
            for (int r = 0; r < NROW; r++) begin
                for (int p = 0; p < NPHYS; p++) begin
                    if (row_rd_wl[r] && !row_wr_wl_n[r] && grp_wr_wl[p % NGRP]) begin
                        cells[r][p] <= wr_data[p / NGRP];
                    end
                end
            end
        end
    end

    // Read path: the row with a grounded foot and a raised word-line
    always_comb begin
        rsel = '0;
        rhit = 1'b0;
        for (int r = 0; r < NROW; r++) begin
            if (row_rd_wl[r] && !row_vgnd[r]) begin
                rsel = RB'(r);
                rhit = 1'b1;
            end
        end
    end

    always_comb begin
        csel = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (col_sel[g]) begin
                csel = CB'(g);
            end
        end
    end

    // Sense latch: captures during read, holds otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rhit) begin
            for (int b = 0; b < WORD_W; b++) begin
                rd_data[b] <= cells[rsel][b * NGRP + int'(csel)];
            end
        end
    end

endmodule

// File: rtl/ilv_wl_decoder.sv
module ilv_wl_decoder
    import ilv_wl_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int COL_BITS = 2,
    parameter int WORD_W   = 16,
    localparam int ROW_BITS = ADDR_W - COL_BITS,
    localparam int NROW     = 1 << ROW_BITS,
    localparam int NGRP     = 1 << COL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_pulse,
    input  logic              wr_pulse,
    input  logic [WORD_W-1:0] wr_data,
    output logic [NROW-1:0]   row_rd_wl,
    output logic [NROW-1:0]   row_wr_wl_n,
    output logic [NROW-1:0]   row_vgnd,
    output logic [NGRP-1:0]   grp_wr_wl,
    output logic [NGRP-1:0]   col_sel,
    output logic [WORD_W-1:0] rd_data
);

    wl_state_e         state;
    logic [ADDR_W-1:0] lat_addr;

    ilv_wl_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .rd_pulse (rd_pulse),
        .wr_pulse (wr_pulse),
        .state    (state),
        .lat_addr (lat_addr)
    );

    ilv_row_drv #(
        .ROW_BITS (ROW_BITS),
        .NROW     (NROW)
    ) u_rows (
        .state       (state),
        .row_addr    (lat_addr[ADDR_W-1:COL_BITS]),
        .row_rd_wl   (row_rd_wl),
        .row_wr_wl_n (row_wr_wl_n),
        .row_vgnd    (row_vgnd)
    );

    ilv_col_drv #(
        .COL_BITS (COL_BITS),
        .NGRP     (NGRP)
    ) u_cols (
        .state     (state),
        .col_addr  (lat_addr[COL_BITS-1:0]),
        .col_sel   (col_sel),
        .grp_wr_wl (grp_wr_wl)
    );

    ilv_cell_array #(
        .NROW   (NROW),
        .NGRP   (NGRP),
        .WORD_W (WORD_W)
    ) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_rd_wl   (row_rd_wl),
        .row_wr_wl_n (row_wr_wl_n),
        .row_vgnd    (row_vgnd),
        .grp_wr_wl   (grp_wr_wl),
        .col_sel     (col_sel),
        .wr_data     (wr_data),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/ilv_wl_checker.sv
module ilv_wl_checker #(
    parameter int NROW   = 16,
    parameter int NGRP   = 4,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_pulse,
    input logic              wr_pulse,
    input logic [NROW-1:0]   row_rd_wl,
    input logic [NROW-1:0]   row_wr_wl_n,
    input logic [NROW-1:0]   row_vgnd,
    input logic [NGRP-1:0]   grp_wr_wl,
    input logic [NGRP-1:0]   col_sel,
    input logic [WORD_W-1:0] rd_data
);

    logic all_hold;
    logic reading;
    assign all_hold = (row_rd_wl == '0) && (&row_wr_wl_n) && (&row_vgnd)
                      && (grp_wr_wl == '0) && (col_sel == '0);
    assign reading  = ((~row_vgnd) != '0);

    assert_col_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_sel));

    assert_row_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_rd_wl));

    assert_read_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reading |-> (row_rd_wl == ~row_vgnd) && (&row_wr_wl_n)
                    && (grp_wr_wl == '0) && ($countones(col_sel) == 1));

    assert_write_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_wr_wl != '0) |-> (row_rd_wl == ~row_wr_wl_n) && (&row_vgnd)
                              && (col_sel == grp_wr_wl) && ($countones(grp_wr_wl) == 1));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_pulse && !wr_pulse) |=> all_hold);

    assert_clash_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pulse && wr_pulse) |=> all_hold);

    assert_read_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pulse && !wr_pulse && reading) |=> $stable(row_rd_wl) && $stable(col_sel));

    assert_write_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !rd_pulse && (grp_wr_wl != '0)) |=>
            $stable(row_rd_wl) && $stable(grp_wr_wl));

    assert_read_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pulse && !wr_pulse) |=> reading);

    assert_write_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !rd_pulse) |=> (grp_wr_wl != '0));

    assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reading |=> $stable(rd_data));

endmodule

bind ilv_wl_decoder ilv_wl_checker #(
    .NROW   (NROW),
    .NGRP   (NGRP),
    .WORD_W (WORD_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_pulse    (rd_pulse),
    .wr_pulse    (wr_pulse),
    .row_rd_wl   (row_rd_wl),
    .row_wr_wl_n (row_wr_wl_n),
    .row_vgnd    (row_vgnd),
    .grp_wr_wl   (grp_wr_wl),
    .col_sel     (col_sel),
    .rd_data     (rd_data)
);

// File: tb/tb_ilv_wl_decoder.sv
`timescale 1ns/1ps
module tb_ilv_wl_decoder;

    localparam int MD_HOLD  = 0;
    localparam int MD_READ  = 1;
    localparam int MD_WRITE = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        rd_pulse = 1'b0;
    logic        wr_pulse = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] row_rd_wl, row_wr_wl_n, row_vgnd, rd_data;
    logic [3:0]  grp_wr_wl, col_sel;

    int checks = 0;
    int failures = 0;
    logic [15:0] mem [64];
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    ilv_wl_decoder dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_pulse(rd_pulse),
        .wr_pulse(wr_pulse), .wr_data(wr_data), .row_rd_wl(row_rd_wl),
        .row_wr_wl_n(row_wr_wl_n), .row_vgnd(row_vgnd), .grp_wr_wl(grp_wr_wl),
        .col_sel(col_sel), .rd_data(rd_data)
    );

    // Expected line vector {rd_wl, wr_wl_n, vgnd, grp, col_sel} from the requirements
    function automatic logic [55:0] exp_lines(input int mode, input logic [5:0] a);
        logic [15:0] rw = 16'h0, wn = 16'hFFFF, vg = 16'hFFFF;
        logic [3:0]  gw = 4'h0, cs = 4'h0;
        logic [15:0] rbit = 16'h1 << a[5:2];
        logic [3:0]  cbit = 4'h1 << a[1:0];
        if (mode == MD_READ) begin
            rw = rbit; vg = ~rbit; cs = cbit;
        end else if (mode == MD_WRITE) begin
            rw = rbit; wn = ~rbit; gw = cbit; cs = cbit;
        end
        return {rw, wn, vg, gw, cs};
    endfunction

    task automatic check_lines(input int mode, input logic [5:0] a, input string req);
        logic [55:0] act = {row_rd_wl, row_wr_wl_n, row_vgnd, grp_wr_wl, col_sel};
        logic [55:0] ex  = exp_lines(mode, a);
        checks++;
        if (act !== ex) begin
            failures++;
            $display("FAIL %s lines actual=%h expected=%h", req, act, ex);
        end
    endtask

    task automatic check_data(input logic [15:0] ex, input string req);
        checks++;
        if (rd_data !== ex) begin
            failures++;
            $display("FAIL %s rd_data actual=%h expected=%h", req, rd_data, ex);
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_pulse = 1'b1;
        @(negedge clk);
        check_lines(MD_WRITE, a, "R6");
        @(negedge clk);
        wr_pulse = 1'b0;
        mem[a] = d;
    endtask

    task automatic do_read(input logic [5:0] a);
        @(negedge clk);
        addr = a; rd_pulse = 1'b1;
        @(negedge clk);
        check_lines(MD_READ, a, "R5");
        @(negedge clk);
        rd_pulse = 1'b0;
        check_data(mem[a], "R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int i = 0; i < 64; i++) mem[i] = 16'h0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_lines(MD_HOLD, 6'd0, "R1");
        check_data(16'h0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_lines(MD_HOLD, 6'd0, "R2");

        // R11: lines do not move in the cycle the pulse is raised
        addr = 6'd9; wr_data = 16'h1234; wr_pulse = 1'b1;
        #1 check_lines(MD_HOLD, 6'd9, "R11");
        @(negedge clk);
        check_lines(MD_WRITE, 6'd9, "R11");
        @(negedge clk);
        wr_pulse = 1'b0; mem[9] = 16'h1234;
        @(negedge clk);
        check_lines(MD_HOLD, 6'd9, "R2");

        // R9: all four words of row 5, then a rewrite of one
        do_write(6'd20, 16'hA5A5);
        do_write(6'd21, 16'h0FF0);
        do_write(6'd22, 16'hFFFF);
        do_write(6'd23, 16'h8001);
        do_write(6'd22, 16'h0000);
        for (int k = 20; k < 24; k++) do_read(6'(k));

        // R3/R4 boundaries
        do_write(6'd0, 16'hBEEF);
        do_write(6'd63, 16'hCAFE);
        do_read(6'd0);
        do_read(6'd63);

        // R10: data kept outside reads
        repeat (4) @(negedge clk);
        check_data(16'hCAFE, "R10");

        // R8: address changed mid-read
        @(negedge clk); addr = 6'd21; rd_pulse = 1'b1;
        @(negedge clk); addr = 6'd0;
        @(negedge clk); check_lines(MD_READ, 6'd21, "R8");
        rd_pulse = 1'b0; check_data(mem[21], "R8");

        // R8: address changed mid-write
        @(negedge clk); addr = 6'd40; wr_data = 16'h5555; wr_pulse = 1'b1;
        @(negedge clk); addr = 6'd41;
        @(negedge clk); check_lines(MD_WRITE, 6'd40, "R8");
        wr_pulse = 1'b0; mem[40] = 16'h5555;
        do_read(6'd40);
        do_read(6'd41);

        // R8: read hands straight over to write with a new address
        @(negedge clk); addr = 6'd12; rd_pulse = 1'b1;
        @(negedge clk);
        @(negedge clk); rd_pulse = 1'b0; wr_pulse = 1'b1; addr = 6'd45; wr_data = 16'h7E7E;
        @(negedge clk); check_lines(MD_WRITE, 6'd45, "R8");
        @(negedge clk); wr_pulse = 1'b0; mem[45] = 16'h7E7E;
        do_read(6'd45);

        // R7: both pulses from idle, then during a read
        @(negedge clk); addr = 6'd20; wr_data = 16'h3C3C; rd_pulse = 1'b1; wr_pulse = 1'b1;
        @(negedge clk); check_lines(MD_HOLD, 6'd20, "R7");
        @(negedge clk); rd_pulse = 1'b0; wr_pulse = 1'b0;
        check_data(mem[45], "R7");
        @(negedge clk); addr = 6'd23; rd_pulse = 1'b1;
        @(negedge clk); check_lines(MD_READ, 6'd23, "R7");
        wr_pulse = 1'b1; wr_data = 16'hFFFF;
        @(negedge clk); check_lines(MD_HOLD, 6'd23, "R7");
        @(negedge clk); rd_pulse = 1'b0; wr_pulse = 1'b0;
        check_data(mem[23], "R7");
        do_read(6'd20);
        do_read(6'd23);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [5:0] a = 6'($urandom_range(0, 63));
            if ($urandom_range(0, 1) == 0) do_write(a, 16'($urandom()));
            else do_read(a);
        end

        @(negedge clk);
        @(negedge clk);
        check_lines(MD_HOLD, 6'd0, "R2");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule